// File: doc/BRIEF.md
# Fractional-Divide Serial Bit Clock Generator

This block derives a serial bit clock from a fast reference tick when the wanted divide ratio is not an integer. A tick is a one-cycle enable on the system clock. Each half period of the output, called a state, lasts a whole number of ticks. A repeating pattern mixes short states of A ticks with long states of A+1 ticks. The average half period is therefore A + (B+1)/(C+1) ticks, and the average output frequency lies between (tick rate/2)/(A+1) and (tick rate/2)/A.

A 32-bit control word holds the three fields. Software computes the fields for a target rate and writes the word with a single-cycle write strobe. The written word is held in a pending register and becomes active only when a pattern completes, so no half period is ever cut short. The block drives a clock level and a one-cycle strobe that marks the start of each new pattern.

Top module: `fracclk_gen`

## Requirements
- R1: While reset is asserted and directly after it, `bit_clk` is 1 and `frame_start` is 0. The active word is the default A=32, B=34, C=63, which gives a 64-state pattern of 2083 ticks.
- R2: The control word carries A in bits 31:22, B in bits 21:12 and C in bits 11:0. All three fields are unsigned.
- R3: When C > B, a pattern is C−B short states of A ticks each, followed by B+1 long states of A+1 ticks each.
- R4: Every state ends by inverting `bit_clk`. The first state after reset is at level 1. With A=2, B=2, C=7 the 19 ticks of one pattern read 1100110011000111000.
- R5: When C ≤ B there are no short states, and the pattern is B+1 long states of A+1 ticks each.
- R6: When A = 0, each short state lasts 1 tick instead of 0 ticks.
- R7: When a pattern has an odd number of states, the next pattern starts at the inverse of the last level instead of restarting at 1.
- R8: A written word becomes active only at the end of the current pattern, which is never truncated. A write in the same cycle as the tick that ends a pattern takes effect one pattern later.
- R9: `frame_start` is high for exactly one cycle, in the cycle after the tick that completes a pattern, and is low at all other times.
- R10: In a cycle without a tick nothing advances, and `bit_clk` keeps its value.
- R11: The slowest setting, A=1023, B=1, C=1, gives two long states of 1024 ticks each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Reference tick enable, one cycle wide |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_word | input | 32 | Control word: A[31:22], B[21:12], C[11:0] |
| bit_clk | output | 1 | Generated serial clock level |
| frame_start | output | 1 | One-cycle strobe at the start of each pattern |

## Verification
The default word is checked over a full pattern: 29 short states of 32 ticks and 35 long states of 33 ticks. The 2/2/7 word is compared bit by bit against its known 19-tick sequence. A 3-state word is run twice back to back; this separates alternation that carries across the boundary from a restart at level 1. Further words with A=0, with C ≤ B and with the largest A show the 1-tick floor, the skipped short phase and the wide counters. Writes placed in the middle of a pattern, and on the very tick that ends one, show whether the new word is deferred and whether the old pattern runs to completion. Runs with idle cycles between ticks check that the level holds while no tick arrives.

// File: rtl/fracclk_gen.sv
module fracclk_gen #(
  parameter int A_W = 10,
  parameter int B_W = 10,
  parameter int C_W = 12,
  parameter logic [A_W+B_W+C_W-1:0] DEF_WORD = 32'h0802_203F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   cfg_we,
  input  logic [A_W+B_W+C_W-1:0] cfg_word,
  output logic                   bit_clk,
  output logic                   frame_start
);
  localparam int CFG_W = A_W + B_W + C_W;
  localparam int S_W   = ((B_W > C_W) ? B_W : C_W) + 1;
  localparam int T_W   = A_W + 1;

  logic [CFG_W-1:0] act_w, pend_w;
  logic [T_W-1:0]   tcnt;
  logic [S_W-1:0]   scnt;

  logic [A_W-1:0] fa;
  logic [S_W-1:0] fb, fc, short_n, last_idx;
  logic [T_W-1:0] len_m1;
  logic           in_short, last_tick, last_state;

  assign fa = act_w[CFG_W-1 -: A_W];
  assign fb = S_W'(act_w[C_W +: B_W]);
  assign fc = S_W'(act_w[0 +: C_W]);

  assign short_n  = (fc > fb) ? (fc - fb) : '0;
  assign last_idx = short_n + fb;
  assign in_short = scnt < short_n;

  always_comb begin
    if (!in_short)      len_m1 = T_W'(fa);
    else if (fa == '0)  len_m1 = '0;
    else                len_m1 = T_W'(fa) - T_W'(1);
  end

  assign last_tick  = tcnt == len_m1;
  assign last_state = scnt == last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_w       <= DEF_WORD;
      pend_w      <= DEF_WORD;
      tcnt        <= '0;
      scnt        <= '0;
      bit_clk     <= 1'b1;
      frame_start <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      if (cfg_we) pend_w <= cfg_word;
      if (tick) begin
        if (last_tick) begin
          tcnt    <= '0;
          bit_clk <= ~bit_clk;
          if (last_state) begin
            scnt        <= '0;
            act_w       <= pend_w;
            frame_start <= 1'b1;
          end else begin
            scnt <= scnt + S_W'(1);
          end
        end else begin
          tcnt <= tcnt + T_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fracclk_gen_chk.sv
module fracclk_gen_chk #(
  parameter int A_W   = 10,
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             bit_clk,
  input logic             frame_start,
  input logic [CFG_W-1:0] act_w,
  input logic [A_W:0]     tcnt
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(bit_clk)); // R10

  AST_START_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(tick)); // R9

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> $stable(act_w)); // R8

  AST_BOUNDARY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bit_clk != $past(bit_clk))); // R7

  AST_STATE_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= {1'b0, act_w[CFG_W-1 -: A_W]}); // R3
endmodule

bind fracclk_gen fracclk_gen_chk #(.A_W(A_W), .CFG_W(A_W+B_W+C_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bit_clk(bit_clk),
  .frame_start(frame_start), .act_w(act_w), .tcnt(tcnt)
);

// File: tb/fracclk_gen_bench.sv
module fracclk_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cfg_we = 1'b0;
  logic [31:0] cfg_word = '0;
  wire bit_clk, frame_start;

  fracclk_gen u_fracclk_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we),
    .cfg_word(cfg_word), .bit_clk(bit_clk), .frame_start(frame_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, gap = 0, hold_bad = 0, exp_len = 0;
  bit s_clk, s_fs, prev_clk = 1'b1, prev_tick = 1'b0, next_start = 1'b1;
  bit exp_bits [4096];
  bit cap_bits [4096];

  function automatic logic [31:0] w(int a, int b, int c);
    return {a[9:0], b[9:0], c[11:0]};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic cyc(input bit t, input bit we, input logic [31:0] wd);
    @(negedge clk);
    s_clk = bit_clk;
    s_fs  = frame_start;
    if (!prev_tick && (s_clk != prev_clk)) hold_bad++;
    prev_clk  = s_clk;
    prev_tick = t;
    tick      = t;
    cfg_we    = we;
    cfg_word  = we ? wd : '0;
  endtask

  task automatic next_tick(input bit we, input logic [31:0] wd, output bit lv, output int fs_n);
    fs_n = 0;
    for (int k = 0; k < gap; k++) begin
      cyc(1'b0, 1'b0, '0);
      fs_n += int'(s_fs);
    end
    cyc(1'b1, we, wd);
    fs_n += int'(s_fs);
    lv = s_clk;
  endtask

  task automatic build(int a, int b, int c, bit start);
    int sh, idx, len;
    bit lv;
    sh = (c > b) ? c - b : 0;
    idx = 0;
    lv = start;
    for (int s = 0; s <= sh + b; s++) begin
      len = (s < sh) ? ((a == 0) ? 1 : a) : a + 1;
      for (int j = 0; j < len; j++) begin
        exp_bits[idx] = lv;
        idx++;
      end
      lv = ~lv;
    end
    exp_len = idx;
  endtask

  task automatic capture(string req, int a, int b, int c, bit first,
                         bit do_wr, int wr_at, logic [31:0] wd);
    int mism, fs_bad, first_i, fsn, at;
    bit lv;
    build(a, b, c, next_start);
    mism = 0; fs_bad = 0; first_i = -1; hold_bad = 0;
    at = (wr_at < 0) ? exp_len - 1 : wr_at;
    for (int i = 0; i < exp_len; i++) begin
      next_tick(do_wr && (i == at), wd, lv, fsn);
      cap_bits[i] = lv;
      if (lv != exp_bits[i]) begin
        mism++;
        if (first_i < 0) first_i = i;
      end
      if (fsn != (((i == 0) && !first) ? 1 : 0)) fs_bad++;
    end
    check(mism == 0, req, $sformatf("level mismatches (first at tick %0d)", first_i), mism, 0);
    check(fs_bad == 0, "R9", "ticks with wrong frame_start count", fs_bad, 0);
    if (gap > 0) check(hold_bad == 0, "R10", "level changes without tick", hold_bad, 0);
    next_start = ~exp_bits[exp_len-1];
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(bit_clk == 1'b1, "R1", "bit_clk in reset", int'(bit_clk), 1);
    check(frame_start == 1'b0, "R1", "frame_start in reset", int'(frame_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bit_clk == 1'b1 && frame_start == 1'b0, "R1", "outputs after reset",
          int'({bit_clk, frame_start}), 2);
    prev_clk = 1'b1;
    prev_tick = 1'b0;
  endtask

  task automatic t_example_string;
    logic [18:0] ref_seq = 19'b1100110011000111000;
    int bad = 0;
    for (int i = 0; i < 19; i++)
      if (cap_bits[i] != ref_seq[18-i]) bad++;
    check(bad == 0, "R4", "2/2/7 sequence vs 1100110011000111000", bad, 0);
  endtask

  task automatic t_last_boundary;
    bit lv;
    int fsn;
    next_tick(1'b0, '0, lv, fsn);
    check(fsn == 1, "R9", "frame_start after final pattern", fsn, 1);
    check(lv == next_start, "R4", "first level of next pattern", int'(lv), int'(next_start));
  endtask

  initial begin
    t_reset();
    // R1 R3 R8: default word; mid-pattern write must not disturb it
    capture("R1", 32, 34, 63, 1'b1, 1'b1, 5, w(2, 2, 7));
    capture("R4", 2, 2, 7, 1'b0, 1'b1, 2, w(1, 0, 2));
    t_example_string();
    capture("R7", 1, 0, 2, 1'b0, 1'b0, 0, '0);
    capture("R7", 1, 0, 2, 1'b0, 1'b1, 1, w(0, 1, 4));
    capture("R6", 0, 1, 4, 1'b0, 1'b1, 0, w(3, 5, 2));
    gap = 2;
    capture("R5", 3, 5, 2, 1'b0, 1'b1, 0, w(1023, 1, 1));
    gap = 0;
    // R8: write on the pattern-ending tick is deferred one pattern
    capture("R11", 1023, 1, 1, 1'b0, 1'b1, -1, w(2, 2, 7));
    capture("R8", 1023, 1, 1, 1'b0, 1'b0, 0, '0);
    capture("R2", 2, 2, 7, 1'b0, 1'b0, 0, '0);
    t_last_boundary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule